// File: doc/BRIEF.md
# Interrupt Controller Indirect Register Window

This block is the software-facing access path of an interrupt controller. The bus sees only two 32-bit locations: a selector that holds a register number, and a data port through which the selected register is read or written. The selector may pick the controller's identification word, its read-only version word, or its arbitration word. It may also pick the lower or upper 32-bit half of any one of the 64-bit routing entries.

The routing table is held outside this block, next to the delivery logic. A write through the data port to a table half leaves the block on a registered write port. That port carries the entry number, a half select, the data and a per-bit write mask. The mask shields the two status bits that software may only read. The block reads the table through a read port whose entry number and half select follow the selector. The block returns the data on the bus one cycle later.

An access has an effect only when it is exactly four bytes wide and goes to one of the two locations. Any other access returns zero and changes nothing.

Top module: `win_regif`

## Requirements
- R1: A 4-byte write to offset 0x00 stores all 32 bits in the selector. A 4-byte read of offset 0x00 returns the stored value. The selector is zero after reset.
- R2: A bus access whose size field is not 4 (bytes), or whose offset is neither 0x00 nor 0x10, reads as zero. As a write it changes neither the selector nor the identification word, and it raises no table write.
- R3: Only bits [7:0] of the selector form the register number. Bits [31:8] do not affect which register the data port at offset 0x10 reaches.
- R4: Register number 0x01 reads as ((NUM_ENTRIES-1) << 16) | 0x11, which is 0x001F0011 with 32 entries. Writes to it have no effect.
- R5: Register number 0x00 is the identification word. A write keeps only bits [27:24] of the data, and every other bit reads as zero. It resets to zero.
- R6: Register number 0x02 reads the same value as the identification word. Writes to it have no effect.
- R7: Register numbers 0x10 to 0x10+2*NUM_ENTRIES-1 select entry (n-0x10)/2. An odd n selects the upper half (ent_rd_hi=1) and an even n the lower half. A read returns ent_rd_data for that entry and half.
- R8: A 4-byte write to offset 0x10 that selects a table half raises ent_wr_en for exactly one cycle, in the cycle after the bus strobe. The port carries that entry and half. For the upper half the mask is all ones. For the lower half the mask clears bit 14 (remote pending) and bit 12 (delivery status), so the mask is 0xFFFFAFFF. ent_wr_data equals the bus data ANDed with the mask.
- R9: Register numbers 0x03 to 0x0F and those at or above 0x10+2*NUM_ENTRIES read as zero. Writes to them raise no table write and leave the identification word unchanged.
- R10: bus_rvalid is high in exactly the cycle after each read strobe, whether or not the access is valid. bus_rdata holds the result during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Single-cycle access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset within the block |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| ent_rd_idx | output | IDX_W (5) | Entry selected for reading |
| ent_rd_hi | output | 1 | Half selected for reading (1 = upper) |
| ent_rd_data | input | 32 | Selected half returned by the table |
| ent_wr_en | output | 1 | Table write pulse |
| ent_wr_idx | output | IDX_W (5) | Entry being written |
| ent_wr_hi | output | 1 | Half being written (1 = upper) |
| ent_wr_data | output | 32 | Masked write data |
| ent_wr_mask | output | 32 | Per-bit write enable |

## Verification
The bench walks every table register number with both reads and writes. The read data is a function of the entry and half, so a wrong divide-by-two or an inverted half select shows up as a value mismatch. The writes tell lower halves from upper halves through the expected mask. The bench also steps through every unmapped number from 0x03 to 0xFF. This separates a decoder that is off by one at either end of the table from a correct one. The bench tries several access sizes and offsets that must be ignored, and checks that each leaves the selector and the table untouched. Selector values with garbage in the upper bits show whether the decode uses only the low byte.

// File: rtl/win_pkg.sv
package win_pkg;
  // What the current register number points at
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_ID   = 3'd1,
    SEL_VER  = 3'd2,
    SEL_ARB  = 3'd3,
    SEL_ENT  = 3'd4
  } sel_e;

  localparam logic [7:0] REGNO_ID  = 8'h00;
  localparam logic [7:0] REGNO_VER = 8'h01;
  localparam logic [7:0] REGNO_ARB = 8'h02;
endpackage

// File: rtl/win_decode.sv
module win_decode
  import win_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int TBL_BASE    = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic [7:0]       regno,
  output sel_e             sel,
  output logic [IDX_W-1:0] ent_idx,
  output logic             ent_hi
);
  localparam logic [8:0] BASE9 = 9'(TBL_BASE);
  localparam logic [8:0] SPAN9 = 9'(2 * NUM_ENTRIES);

  logic [8:0] rel;

  always_comb begin
    rel     = {1'b0, regno} - BASE9;
    ent_idx = IDX_W'(rel >> 1);
    ent_hi  = rel[0];
    if (regno == REGNO_ID)
      sel = SEL_ID;
    else if (regno == REGNO_VER)
      sel = SEL_VER;
    else if (regno == REGNO_ARB)
      sel = SEL_ARB;
    else if (({1'b0, regno} >= BASE9) && (rel < SPAN9))
      sel = SEL_ENT;
    else
      sel = SEL_NONE;
  end
endmodule

// File: rtl/win_id_reg.sv
module win_id_reg #(
  parameter int ID_LSB = 24,
  parameter int ID_W   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [ID_W-1:0] wr_field,
  output logic [31:0]     id_word
);
  logic [ID_W-1:0] id_q;

  always_ff @(posedge clk) begin
    if (rst)
      id_q <= '0;
    else if (wr_en)
      id_q <= wr_field;
  end

  always_comb begin
    id_word = '0;
    id_word[ID_LSB +: ID_W] = id_q;
  end
endmodule

// File: rtl/win_entry_port.sv
module win_entry_port #(
  parameter int          IDX_W      = 5,
  parameter logic [31:0] RO_MASK_LO = 32'h0000_5000,
  parameter logic [31:0] RO_MASK_HI = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_hi,
  input  logic [31:0]      req_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_hi,
  output logic [31:0]      wr_data,
  output logic [31:0]      wr_mask
);
  logic [31:0] mask_n;

  always_comb mask_n = req_hi ? ~RO_MASK_HI : ~RO_MASK_LO;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_hi   <= 1'b0;
      wr_data <= '0;
      wr_mask <= '0;
    end else begin
      wr_en <= req;
      if (req) begin
        wr_idx  <= req_idx;
        wr_hi   <= req_hi;
        wr_data <= req_data & mask_n;
        wr_mask <= mask_n;
      end
    end
  end
endmodule

// File: rtl/win_regif.sv
module win_regif
  import win_pkg::*;
#(
  parameter int          NUM_ENTRIES = 32,
  parameter int          ADDR_W      = 8,
  parameter int          OFS_SEL     = 0,
  parameter int          OFS_DATA    = 16,
  parameter int          TBL_BASE    = 16,
  parameter int          ID_LSB      = 24,
  parameter int          ID_W        = 4,
  parameter int          MAXENT_LSB  = 16,
  parameter logic [7:0]  VER_CODE    = 8'h11,
  parameter logic [31:0] RO_MASK_LO  = 32'h0000_5000,
  parameter int          IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [IDX_W-1:0]  ent_rd_idx,
  output logic              ent_rd_hi,
  input  logic [31:0]       ent_rd_data,
  output logic              ent_wr_en,
  output logic [IDX_W-1:0]  ent_wr_idx,
  output logic              ent_wr_hi,
  output logic [31:0]       ent_wr_data,
  output logic [31:0]       ent_wr_mask
);
  localparam logic [31:0] VER_WORD =
    (32'(NUM_ENTRIES - 1) << MAXENT_LSB) | 32'(VER_CODE);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFS_SEL);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

  logic [31:0]      index_q;
  logic             size_ok, hit_sel, hit_data;
  sel_e             sel;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_hi;
  logic [31:0]      id_word;
  logic [31:0]      win_rdata;

  always_comb begin
    size_ok  = bus_valid && (bus_size == 4'd4);
    hit_sel  = size_ok && (bus_addr == A_SEL);
    hit_data = size_ok && (bus_addr == A_DATA);
  end

  always_ff @(posedge clk) begin
    if (rst)
      index_q <= '0;
    else if (hit_sel && bus_write)
      index_q <= bus_wdata;
  end

  win_decode #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .TBL_BASE   (TBL_BASE),
    .IDX_W      (IDX_W)
  ) u_dec (
    .regno  (index_q[7:0]),
    .sel    (sel),
    .ent_idx(dec_idx),
    .ent_hi (dec_hi)
  );

  win_id_reg #(
    .ID_LSB(ID_LSB),
    .ID_W  (ID_W)
  ) u_id (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (hit_data && bus_write && (sel == SEL_ID)),
    .wr_field(bus_wdata[ID_LSB +: ID_W]),
    .id_word (id_word)
  );

  win_entry_port #(
    .IDX_W     (IDX_W),
    .RO_MASK_LO(RO_MASK_LO),
    .RO_MASK_HI(32'h0000_0000)
  ) u_wport (
    .clk     (clk),
    .rst     (rst),
    .req     (hit_data && bus_write && (sel == SEL_ENT)),
    .req_idx (dec_idx),
    .req_hi  (dec_hi),
    .req_data(bus_wdata),
    .wr_en   (ent_wr_en),
    .wr_idx  (ent_wr_idx),
    .wr_hi   (ent_wr_hi),
    .wr_data (ent_wr_data),
    .wr_mask (ent_wr_mask)
  );

  always_comb begin
    ent_rd_idx = dec_idx;
    ent_rd_hi  = dec_hi;
    unique case (sel)
      SEL_ID:  win_rdata = id_word;
      SEL_ARB: win_rdata = id_word;
      SEL_VER: win_rdata = VER_WORD;
      SEL_ENT: win_rdata = ent_rd_data;
      default: win_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) begin
        if (hit_sel)
          bus_rdata <= index_q;
        else if (hit_data)
          bus_rdata <= win_rdata;
        else
          bus_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/win_regif_chk.sv
module win_regif_chk #(
  parameter int          ADDR_W     = 8,
  parameter int          OFS_DATA   = 16,
  parameter logic [31:0] VER_WORD   = 32'h001F_0011,
  parameter logic [31:0] RO_MASK_LO = 32'h0000_5000
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_size,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              ent_wr_en,
  input logic              ent_wr_hi,
  input logic [31:0]       ent_wr_data,
  input logic [31:0]       ent_wr_mask,
  input logic [31:0]       index_q
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

  // R8: the lower half never lets the status bits through
  assert_ro_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (ent_wr_en && !ent_wr_hi) |->
      (((ent_wr_mask & RO_MASK_LO) == 32'h0) && ((ent_wr_data & RO_MASK_LO) == 32'h0)));

  // R8: a table write always follows a valid data-port write strobe
  assert_wr_source_R8: assert property (@(posedge clk) disable iff (rst)
    ent_wr_en |-> $past(bus_valid && bus_write && (bus_size == 4'd4) && (bus_addr == A_DATA)));

  // R2: wrong-size writes are dropped
  assert_bad_size_wr_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && (bus_size != 4'd4)) |=> (!ent_wr_en && $stable(index_q)));

  // R2: wrong-size reads return zero
  assert_bad_size_rd_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && (bus_size != 4'd4)) |=> (bus_rvalid && (bus_rdata == 32'h0)));

  // R4: version word is constant
  assert_version_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && (bus_size == 4'd4) && (bus_addr == A_DATA) &&
     (index_q[7:0] == 8'h01)) |=> (bus_rdata == VER_WORD));

  // R10: read data valid only after a read strobe
  assert_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_valid && !bus_write));
endmodule

bind win_regif win_regif_chk #(
  .ADDR_W    (ADDR_W),
  .OFS_DATA  (OFS_DATA),
  .VER_WORD  (VER_WORD),
  .RO_MASK_LO(RO_MASK_LO)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_size   (bus_size),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .ent_wr_en  (ent_wr_en),
  .ent_wr_hi  (ent_wr_hi),
  .ent_wr_data(ent_wr_data),
  .ent_wr_mask(ent_wr_mask),
  .index_q    (index_q)
);

// File: tb/tb_win_regif.sv
module tb_win_regif;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [4:0]  ent_rd_idx;
  logic        ent_rd_hi;
  logic [31:0] ent_rd_data;
  logic        ent_wr_en;
  logic [4:0]  ent_wr_idx;
  logic        ent_wr_hi;
  logic [31:0] ent_wr_data;
  logic [31:0] ent_wr_mask;

  int total = 0;
  int bad = 0;

  logic [31:0] c_rdata;
  logic        c_rvalid, c_we, c_whi;
  logic [4:0]  c_widx;
  logic [31:0] c_wdata, c_wmask;

  always #10 clk = ~clk;

  function automatic logic [31:0] tbl_val(input int idx, input logic hi);
    if (hi) return 32'hA500_0001 | (32'(idx) << 8);
    else    return 32'h0000_5A00 ^ (32'(idx) * 32'h0101_0003);
  endfunction

  always_comb ent_rd_data = tbl_val(int'(ent_rd_idx), ent_rd_hi);

  win_regif dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ent_rd_idx(ent_rd_idx), .ent_rd_hi(ent_rd_hi), .ent_rd_data(ent_rd_data),
    .ent_wr_en(ent_wr_en), .ent_wr_idx(ent_wr_idx), .ent_wr_hi(ent_wr_hi),
    .ent_wr_data(ent_wr_data), .ent_wr_mask(ent_wr_mask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [7:0] a, input logic [3:0] sz,
                     input logic [31:0] wd);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    c_rdata = bus_rdata; c_rvalid = bus_rvalid;
    c_we = ent_wr_en; c_widx = ent_wr_idx; c_whi = ent_wr_hi;
    c_wdata = ent_wr_data; c_wmask = ent_wr_mask;
  endtask

  task automatic wr4(input logic [7:0] a, input logic [31:0] d);
    acc(1'b1, a, 4'd4, d);
  endtask

  task automatic rd4(input logic [7:0] a, input string req);
    acc(1'b0, a, 4'd4, 32'h0);
    chk({req, " R10 rvalid"}, 32'(c_rvalid), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] idv;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R5 reset values
    rd4(8'h00, "R1");
    chk("R1 selector reset", c_rdata, 32'h0);
    rd4(8'h10, "R5");
    chk("R5 id reset", c_rdata, 32'h0);

    // R1 selector readback
    foreach (idv_list[i]) begin
      wr4(8'h00, idv_list[i]);
      rd4(8'h00, "R1");
      chk("R1 selector readback", c_rdata, idv_list[i]);
    end

    // R5 identification word keeps only bits 27:24
    wr4(8'h00, 32'h0);
    foreach (idv_list[i]) begin
      wr4(8'h10, idv_list[i]);
      rd4(8'h10, "R5");
      chk("R5 id field", c_rdata, idv_list[i] & 32'h0F00_0000);
    end
    wr4(8'h10, 32'h0A00_0000);
    idv = 32'h0A00_0000;

    // R6 arbitration mirrors id, write ignored
    wr4(8'h00, 32'h2);
    rd4(8'h10, "R6");
    chk("R6 arb equals id", c_rdata, idv);
    wr4(8'h10, 32'hFFFF_FFFF);
    rd4(8'h10, "R6");
    chk("R6 arb write ignored", c_rdata, idv);

    // R4 version, R3 upper selector bits ignored
    wr4(8'h00, 32'h1);
    rd4(8'h10, "R4");
    chk("R4 version", c_rdata, 32'(((N - 1) << 16) | 32'h11));
    wr4(8'h10, 32'hFFFF_FFFF);
    rd4(8'h10, "R4");
    chk("R4 version write ignored", c_rdata, 32'h001F_0011);
    wr4(8'h00, 32'hDEAD_BE01);
    rd4(8'h10, "R3");
    chk("R3 low byte decode version", c_rdata, 32'h001F_0011);
    wr4(8'h00, 32'h7700_0000);
    rd4(8'h10, "R3");
    chk("R3 low byte decode id", c_rdata, idv);

    // R7 every table read
    for (int n = 16; n < 16 + 2 * N; n++) begin
      wr4(8'h00, 32'(n) | 32'h5500_0000);
      rd4(8'h10, "R7");
      chk("R7 table read", c_rdata, tbl_val((n - 16) / 2, n[0]));
    end

    // R8 every table write
    for (int n = 16; n < 16 + 2 * N; n++) begin
      logic [31:0] wd, m;
      wd = 32'hFFFF_FFFF ^ (32'(n) * 32'h0001_0001);
      m  = n[0] ? 32'hFFFF_FFFF : 32'hFFFF_AFFF;
      wr4(8'h00, 32'(n));
      wr4(8'h10, wd);
      chk("R8 wr_en", 32'(c_we), 32'd1);
      chk("R8 wr_idx", 32'(c_widx), 32'((n - 16) / 2));
      chk("R8 wr_hi", 32'(c_whi), 32'(n[0]));
      chk("R8 wr_mask", c_wmask, m);
      chk("R8 wr_data", c_wdata, wd & m);
    end
    @(negedge clk);
    chk("R8 single pulse", 32'(ent_wr_en), 32'd0);

    // R9 unmapped numbers
    for (int n = 3; n < 256; n++) begin
      if (n >= 16 && n < 16 + 2 * N) continue;
      wr4(8'h00, 32'(n));
      rd4(8'h10, "R9");
      chk("R9 unmapped read", c_rdata, 32'h0);
      wr4(8'h10, 32'hFFFF_FFFF);
      chk("R9 unmapped no write", 32'(c_we), 32'd0);
    end
    wr4(8'h00, 32'h0);
    rd4(8'h10, "R9");
    chk("R9 id unchanged", c_rdata, idv);

    // R2 bad size / bad offset
    wr4(8'h00, 32'h0000_0020);
    foreach (bad_sz[i]) begin
      acc(1'b1, 8'h00, bad_sz[i], 32'h0000_0000);
      rd4(8'h00, "R2");
      chk("R2 bad size selector kept", c_rdata, 32'h20);
      acc(1'b0, 8'h00, bad_sz[i], 32'h0);
      chk("R2 bad size read zero", c_rdata, 32'h0);
      acc(1'b1, 8'h10, bad_sz[i], 32'h1234_5678);
      chk("R2 bad size no table write", 32'(c_we), 32'd0);
    end
    foreach (bad_ofs[i]) begin
      acc(1'b0, bad_ofs[i], 4'd4, 32'h0);
      chk("R2 bad offset read zero", c_rdata, 32'h0);
      wr4(bad_ofs[i], 32'h0000_0000);
      chk("R2 bad offset no table write", 32'(c_we), 32'd0);
      rd4(8'h00, "R2");
      chk("R2 bad offset selector kept", c_rdata, 32'h20);
    end
    wr4(8'h00, 32'h0);
    acc(1'b1, 8'h10, 4'd2, 32'h0500_0000);
    rd4(8'h10, "R2");
    chk("R2 bad size id kept", c_rdata, idv);

    // R10 no rvalid after a write
    wr4(8'h00, 32'h0);
    chk("R10 no rvalid on write", 32'(c_rvalid), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [31:0] idv_list [4] = '{32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0000_0001, 32'h1234_5678};
  logic [3:0]  bad_sz   [4] = '{4'd0, 4'd1, 4'd2, 4'd8};
  logic [7:0]  bad_ofs  [5] = '{8'h04, 8'h08, 8'h0C, 8'h14, 8'h20};
endmodule